// File: doc/BRIEF.md
# Integer Execution Unit with Relational Status Flags

This block is the integer execution stage of a 32-bit processor datapath. An already decoded 6-bit operation code selects one computation on two register operands, a 16-bit immediate and a 5-bit shift count. The result appears combinationally in the same cycle. The datapath then writes it to the destination register. Operand fetch, memory access and the program-counter update all sit outside the block.

A six-bit status register sits beside the datapath and is updated on the rising clock edge. A compare writes five signed relational flags and a zero flag. Most other data-producing operations rewrite only the zero flag and leave the relational flags as they were. The two immediate-load operations do not touch the status register. The fetch stage asks a separate port whether a given jump code would be taken under the current flags. For the upper-immediate load, operand A carries the old contents of the destination register so that its low half can be kept. A side input chooses whether the sign-extending move works from a byte or from a halfword.

Top module: `exec_flag_core`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `status_word` is all zero. The flag layout is bit0 equal, bit1 greater, bit2 greater-or-equal, bit3 less, bit4 less-or-equal, bit5 zero. Bits 31:6 always read zero.
- R2: Compare (code 0x14) treats A and B as signed. At the next clock edge it sets bits 0 to 4 to (A==B, A>B, A>=B, A<B, A<=B) and bit5 to (A-B==0). The result output is A-B.
- R3: The following codes rewrite only bit5 at the next edge, setting it exactly when the result is zero: MOV 0x01, MOVS 0x02, INC 0x15, DEC 0x16, SHL 0x17, SHR 0x18, ADD 0x19, SUB 0x1A, AND..XNOR 0x1B-0x21, IADD 0x25, ISUB 0x26. Bits 0 to 4 keep their values.
- R4: The result is computed modulo 2^32 as follows:
  - ADD gives A+B and SUB gives A-B.
  - INC gives A+1 and DEC gives A-1.
  - IADD gives A+sext(imm) and ISUB gives A-sext(imm), where the 16-bit immediate is sign-extended first.
- R5: Bitwise and move operations produce:
  - MOV gives A and NOT gives ~A.
  - AND 0x1B, OR 0x1C, XOR 0x1E, NAND 0x1F, NOR 0x20 and XNOR 0x21 combine A with B bitwise.
- R6: MOVS sign-extends A from bit 15 when `sext_half`=1 and from bit 7 when `sext_half`=0.
- R7: SHL and SHR shift A logically and fill with zeros. The amount is `shamt` when it is non-zero; otherwise it is B[4:0].
- R8: LLI (0x0B) yields {16'h0, imm}. LUI (0x0C) yields {imm, A[15:0]}. Neither changes any status bit.
- R9: Any other code, including 0x00 and the memory, jump and system codes, yields a result of 0 and leaves the status register unchanged.
- R10: `jump_taken` is evaluated from the current status register as follows:
  - 0x0D is always taken.
  - 0x0E needs equal set, and 0x0F needs equal clear.
  - 0x10 needs greater set, and 0x11 needs greater or equal set.
  - 0x12 needs less set, and 0x13 needs less or equal set.
  - Every other `jump_op` gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Decoded operation code |
| opnd_a | input | 32 | First operand; old destination value for LUI |
| opnd_b | input | 32 | Second operand; shift count source when `shamt` is zero |
| imm | input | 16 | Immediate field |
| shamt | input | 5 | Literal shift count |
| sext_half | input | 1 | MOVS width: 1 halfword, 0 byte |
| jump_op | input | 6 | Jump code to evaluate against the flags |
| result | output | 32 | Combinational result |
| status_word | output | 32 | Registered status flags, upper bits zero |
| jump_taken | output | 1 | Branch decision for `jump_op` |

## Verification
The only state is the six flag bits. A wrong flag never shows on `result`. It shows one cycle after the operation on `status_word`, and it also shows through `jump_taken` for any later jump code that reads the bit. A stale or wrongly held relational bit stays hidden until a later compare overwrites it. The bench therefore compares the whole status word on every cycle and interleaves compares with zero-only writers. This catches a corrupted hold at the first edge where it occurs. Signed-overflow corner compares and pairs of equal operands are aimed at the boundary between the greater and less flags.

// File: rtl/exu_pkg.sv
package exu_pkg;

   // operation codes; values are fixed by the decoder feeding this block
   localparam logic [5:0] OPC_NOP  = 6'h00;
   localparam logic [5:0] OPC_MOV  = 6'h01;
   localparam logic [5:0] OPC_MOVS = 6'h02;
   localparam logic [5:0] OPC_LLI  = 6'h0B;
   localparam logic [5:0] OPC_LUI  = 6'h0C;
   localparam logic [5:0] OPC_JMP  = 6'h0D;
   localparam logic [5:0] OPC_JEQ  = 6'h0E;
   localparam logic [5:0] OPC_JNE  = 6'h0F;
   localparam logic [5:0] OPC_JGT  = 6'h10;
   localparam logic [5:0] OPC_JGE  = 6'h11;
   localparam logic [5:0] OPC_JLT  = 6'h12;
   localparam logic [5:0] OPC_JLE  = 6'h13;
   localparam logic [5:0] OPC_CMP  = 6'h14;
   localparam logic [5:0] OPC_INC  = 6'h15;
   localparam logic [5:0] OPC_DEC  = 6'h16;
   localparam logic [5:0] OPC_SHL  = 6'h17;
   localparam logic [5:0] OPC_SHR  = 6'h18;
   localparam logic [5:0] OPC_ADD  = 6'h19;
   localparam logic [5:0] OPC_SUB  = 6'h1A;
   localparam logic [5:0] OPC_AND  = 6'h1B;
   localparam logic [5:0] OPC_OR   = 6'h1C;
   localparam logic [5:0] OPC_NOT  = 6'h1D;
   localparam logic [5:0] OPC_XOR  = 6'h1E;
   localparam logic [5:0] OPC_NAND = 6'h1F;
   localparam logic [5:0] OPC_NOR  = 6'h20;
   localparam logic [5:0] OPC_XNOR = 6'h21;
   localparam logic [5:0] OPC_IADD = 6'h25;
   localparam logic [5:0] OPC_ISUB = 6'h26;

   // status bit positions (consumed by branch logic downstream)
   localparam int FLG_EQ  = 0;
   localparam int FLG_GT  = 1;
   localparam int FLG_GE  = 2;
   localparam int FLG_LT  = 3;
   localparam int FLG_LE  = 4;
   localparam int FLG_Z   = 5;
   localparam int FLG_NUM = 6;

   typedef struct packed {
      logic zero;
      logic le;
      logic lt;
      logic ge;
      logic gt;
      logic eq;
   } flag_bits_t;

   // operations whose result feeds the zero flag
   function automatic logic op_sets_zero(input logic [5:0] op);
      case (op)
         OPC_MOV, OPC_MOVS, OPC_INC, OPC_DEC, OPC_SHL, OPC_SHR,
         OPC_ADD, OPC_SUB, OPC_AND, OPC_OR, OPC_NOT, OPC_XOR,
         OPC_NAND, OPC_NOR, OPC_XNOR, OPC_IADD, OPC_ISUB: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic op_is_adder(input logic [5:0] op);
      case (op)
         OPC_INC, OPC_DEC, OPC_ADD, OPC_SUB,
         OPC_IADD, OPC_ISUB, OPC_CMP: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic op_is_bitwise(input logic [5:0] op);
      case (op)
         OPC_MOV, OPC_MOVS, OPC_AND, OPC_OR, OPC_NOT, OPC_XOR,
         OPC_NAND, OPC_NOR, OPC_XNOR, OPC_LLI, OPC_LUI: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic op_is_shift(input logic [5:0] op);
      return (op == OPC_SHL) || (op == OPC_SHR);
   endfunction

endpackage

// File: rtl/exu_arith.sv
module exu_arith
   import exu_pkg::*;
#(
   parameter int WIDTH = 32,
   parameter int IMM_W = 16
) (
   input  logic [5:0]       opcode,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [IMM_W-1:0] imm,
   output logic [WIDTH-1:0] sum,
   output flag_bits_t       rel
);
   localparam int MSB = WIDTH - 1;
   localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

   logic [WIDTH-1:0] imm_sx;
   logic [WIDTH-1:0] addend;
   logic [WIDTH-1:0] addend_eff;
   logic             negate;
   logic             ovf;
   logic             less;
   logic             same;

   assign imm_sx = {{(WIDTH-IMM_W){imm[IMM_W-1]}}, imm};

   always_comb begin
      addend = opnd_b;
      negate = 1'b0;
      case (opcode)
         OPC_INC:  addend = ONE;
         OPC_DEC:  begin addend = ONE;    negate = 1'b1; end
         OPC_SUB:  negate = 1'b1;
         OPC_CMP:  negate = 1'b1;
         OPC_IADD: addend = imm_sx;
         OPC_ISUB: begin addend = imm_sx; negate = 1'b1; end
         default:  ;
      endcase
   end

   // one shared adder; subtraction by inverted addend plus carry-in
   assign addend_eff = negate ? ~addend : addend;
   assign sum        = opnd_a + addend_eff + (negate ? ONE : '0);

   // signed less-than from difference sign corrected by overflow
   assign ovf  = (opnd_a[MSB] == addend_eff[MSB]) && (sum[MSB] != opnd_a[MSB]);
   assign less = sum[MSB] ^ ovf;
   assign same = ~|sum;

   assign rel.eq   = same;
   assign rel.lt   = less;
   assign rel.le   = less | same;
   assign rel.gt   = ~less & ~same;
   assign rel.ge   = ~less;
   assign rel.zero = same;

   always_comb begin
      if (opcode == OPC_CMP) begin
         assert_lt_signed_R2: assert (less == ($signed(opnd_a) < $signed(opnd_b)))
            else $error("signed less-than disagrees with operator compare");
      end
   end

endmodule

// File: rtl/exu_bitwise.sv
module exu_bitwise
   import exu_pkg::*;
#(
   parameter int WIDTH  = 32,
   parameter int IMM_W  = 16,
   parameter int BYTE_W = 8,
   parameter int HALF_W = 16
) (
   input  logic [5:0]       opcode,
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [WIDTH-1:0] opnd_b,
   input  logic [IMM_W-1:0] imm,
   input  logic             sext_half,
   output logic [WIDTH-1:0] res
);
   localparam int KEEP_W = WIDTH - IMM_W;

   logic [WIDTH-1:0] sx_byte;
   logic [WIDTH-1:0] sx_half;

   assign sx_byte = {{(WIDTH-BYTE_W){opnd_a[BYTE_W-1]}}, opnd_a[BYTE_W-1:0]};
   assign sx_half = {{(WIDTH-HALF_W){opnd_a[HALF_W-1]}}, opnd_a[HALF_W-1:0]};

   always_comb begin
      case (opcode)
         OPC_MOV:  res = opnd_a;
         OPC_MOVS: res = sext_half ? sx_half : sx_byte;
         OPC_AND:  res = opnd_a & opnd_b;
         OPC_OR:   res = opnd_a | opnd_b;
         OPC_NOT:  res = ~opnd_a;
         OPC_XOR:  res = opnd_a ^ opnd_b;
         OPC_NAND: res = ~(opnd_a & opnd_b);
         OPC_NOR:  res = ~(opnd_a | opnd_b);
         OPC_XNOR: res = ~(opnd_a ^ opnd_b);
         OPC_LLI:  res = {{KEEP_W{1'b0}}, imm};
         OPC_LUI:  res = {imm, opnd_a[KEEP_W-1:0]};
         default:  res = '0;
      endcase
   end

   always_comb begin
      if (opcode == OPC_LLI) begin
         assert_lli_clears_R8: assert (res[WIDTH-1:IMM_W] == '0)
            else $error("lower immediate load left upper bits set");
      end
   end

endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
   parameter int WIDTH       = 32,
   parameter int SHIFT_STYLE = 0,
   localparam int SW         = $clog2(WIDTH)
) (
   input  logic [WIDTH-1:0] opnd_a,
   input  logic [SW-1:0]    amt_reg,
   input  logic [SW-1:0]    amt_lit,
   input  logic             left,
   output logic [WIDTH-1:0] res
);
   logic [SW-1:0] amt;

   // literal count wins; a zero literal defers to the register count
   assign amt = (amt_lit != '0) ? amt_lit : amt_reg;

   generate
      if (SHIFT_STYLE == 0) begin : g_staged
         logic [WIDTH-1:0] stage [0:SW];
         assign stage[0] = opnd_a;
         for (genvar k = 0; k < SW; k++) begin : g_lvl
            assign stage[k+1] = !amt[k] ? stage[k]
                              : (left ? (stage[k] << (1 << k)) : (stage[k] >> (1 << k)));
         end
         assign res = stage[SW];
      end else begin : g_flat
         assign res = left ? (opnd_a << amt) : (opnd_a >> amt);
      end
   endgenerate

endmodule

// File: rtl/exu_flags.sv
module exu_flags
   import exu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [5:0]       opcode,
   input  logic             res_zero,
   input  flag_bits_t       rel,
   input  logic [5:0]       jump_op,
   output logic [WIDTH-1:0] status_word,
   output logic             jump_taken
);
   flag_bits_t st_q;
   logic       is_cmp;

   assign is_cmp = (opcode == OPC_CMP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
      end else if (is_cmp) begin
         st_q <= rel;
      end else if (op_sets_zero(opcode)) begin
         st_q.zero <= res_zero;
      end
   end

   assign status_word = {{(WIDTH-FLG_NUM){1'b0}}, st_q};

   always_comb begin
      case (jump_op)
         OPC_JMP: jump_taken = 1'b1;
         OPC_JEQ: jump_taken = st_q.eq;
         OPC_JNE: jump_taken = ~st_q.eq;
         OPC_JGT: jump_taken = st_q.gt;
         OPC_JGE: jump_taken = st_q.gt | st_q.eq;
         OPC_JLT: jump_taken = st_q.lt;
         OPC_JLE: jump_taken = st_q.lt | st_q.eq;
         default: jump_taken = 1'b0;
      endcase
   end

   // checker state: what the last edge did and the relational bits before it
   logic       cmp_last_q;
   logic       hold_last_q;
   logic [4:0] rel_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_last_q  <= 1'b0;
         hold_last_q <= 1'b0;
         rel_prev_q  <= '0;
      end else begin
         cmp_last_q  <= is_cmp;
         hold_last_q <= ~is_cmp;
         rel_prev_q  <= st_q[4:0];
      end
   end

   assert_cmp_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_last_q |-> $countones({st_q.gt, st_q.eq, st_q.lt}) == 1);

   assert_cmp_consistent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_last_q |-> (st_q.ge == (st_q.gt | st_q.eq)) && (st_q.le == (st_q.lt | st_q.eq))
                     && (st_q.zero == st_q.eq));

   assert_rel_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hold_last_q |-> st_q[4:0] == rel_prev_q);

   assert_jump_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (jump_op < OPC_JMP || jump_op > OPC_JLE) |-> !jump_taken);

endmodule

// File: rtl/exec_flag_core.sv
module exec_flag_core
   import exu_pkg::*;
#(
   parameter int  WIDTH       = 32,
   parameter int  IMM_W       = 16,
   parameter int  SHIFT_STYLE = 0,
   localparam int SHAMT_W     = $clog2(WIDTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [5:0]         opcode,
   input  logic [WIDTH-1:0]   opnd_a,
   input  logic [WIDTH-1:0]   opnd_b,
   input  logic [IMM_W-1:0]   imm,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic               sext_half,
   input  logic [5:0]         jump_op,
   output logic [WIDTH-1:0]   result,
   output logic [WIDTH-1:0]   status_word,
   output logic               jump_taken
);
   generate
      if ((1 << SHAMT_W) != WIDTH) begin : g_chk_pow2
         $error("WIDTH must be a power of two");
      end
      if (WIDTH < 2 * IMM_W) begin : g_chk_imm
         $error("WIDTH must hold two immediates");
      end
      if (SHIFT_STYLE < 0 || SHIFT_STYLE > 1) begin : g_chk_style
         $error("SHIFT_STYLE must be 0 or 1");
      end
   endgenerate

   logic [WIDTH-1:0] add_res;
   logic [WIDTH-1:0] bit_res;
   logic [WIDTH-1:0] shf_res;
   flag_bits_t       rel;

   exu_arith #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_arith (
      .opcode (opcode),
      .opnd_a (opnd_a),
      .opnd_b (opnd_b),
      .imm    (imm),
      .sum    (add_res),
      .rel    (rel)
   );

   exu_bitwise #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_bitwise (
      .opcode    (opcode),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .imm       (imm),
      .sext_half (sext_half),
      .res       (bit_res)
   );

   exu_shift #(.WIDTH(WIDTH), .SHIFT_STYLE(SHIFT_STYLE)) u_shift (
      .opnd_a  (opnd_a),
      .amt_reg (opnd_b[SHAMT_W-1:0]),
      .amt_lit (shamt),
      .left    (opcode == OPC_SHL),
      .res     (shf_res)
   );

   always_comb begin
      if (op_is_adder(opcode))        result = add_res;
      else if (op_is_bitwise(opcode)) result = bit_res;
      else if (op_is_shift(opcode))   result = shf_res;
      else                            result = '0;
   end

   exu_flags #(.WIDTH(WIDTH)) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .opcode      (opcode),
      .res_zero    (~|result),
      .rel         (rel),
      .jump_op     (jump_op),
      .status_word (status_word),
      .jump_taken  (jump_taken)
   );

endmodule

// File: tb/exec_flag_core_test.sv
`timescale 1ns/1ps
module exec_flag_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  opcode = '0;
   logic [31:0] opnd_a = '0;
   logic [31:0] opnd_b = '0;
   logic [15:0] imm = '0;
   logic [4:0]  shamt = '0;
   logic        sext_half = 1'b0;
   logic [5:0]  jump_op = '0;
   logic [31:0] result;
   logic [31:0] status_word;
   logic        jump_taken;

   int n_run  = 0;
   int n_fail = 0;
   logic [5:0] m_st = '0;
   logic [5:0] prev_op = '0;

   always #2 clk = ~clk;

   exec_flag_core uut (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .opnd_a(opnd_a), .opnd_b(opnd_b),
      .imm(imm), .shamt(shamt), .sext_half(sext_half), .jump_op(jump_op),
      .result(result), .status_word(status_word), .jump_taken(jump_taken)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic bit zero_writer(input logic [5:0] op);
      return op inside {6'h01, 6'h02, [6'h15:6'h21], 6'h25, 6'h26};
   endfunction

   function automatic string req_of(input logic [5:0] op);
      if (op == 6'h14) return "R2";
      if (op == 6'h02) return "R6";
      if (op == 6'h17 || op == 6'h18) return "R7";
      if (op == 6'h0B || op == 6'h0C) return "R8";
      if (op inside {6'h15, 6'h16, 6'h19, 6'h1A, 6'h25, 6'h26}) return "R4";
      if (op == 6'h01 || (op >= 6'h1B && op <= 6'h21)) return "R5";
      return "R9";
   endfunction

   function automatic logic [31:0] ref_result(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                                              input logic [15:0] im, input logic [4:0] sh, input logic hf);
      logic [31:0] sx;
      int amt;
      sx  = {{16{im[15]}}, im};
      amt = (sh != 0) ? int'(sh) : int'(b[4:0]);
      case (op)
         6'h01: return a;
         6'h02: return hf ? {{16{a[15]}}, a[15:0]} : {{24{a[7]}}, a[7:0]};
         6'h0B: return {16'h0, im};
         6'h0C: return {im, a[15:0]};
         6'h14: return a - b;
         6'h15: return a + 1;
         6'h16: return a - 1;
         6'h17: return a << amt;
         6'h18: return a >> amt;
         6'h19: return a + b;
         6'h1A: return a - b;
         6'h1B: return a & b;
         6'h1C: return a | b;
         6'h1D: return ~a;
         6'h1E: return a ^ b;
         6'h1F: return ~(a & b);
         6'h20: return ~(a | b);
         6'h21: return ~(a ^ b);
         6'h25: return a + sx;
         6'h26: return a - sx;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [5:0] ref_flags(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                                            input logic [31:0] r, input logic [5:0] old);
      logic [5:0] n;
      n = old;
      if (op == 6'h14) begin
         n[0] = (a == b);
         n[1] = ($signed(a) >  $signed(b));
         n[2] = ($signed(a) >= $signed(b));
         n[3] = ($signed(a) <  $signed(b));
         n[4] = ($signed(a) <= $signed(b));
         n[5] = ((a - b) == 0);
      end else if (zero_writer(op)) begin
         n[5] = (r == 0);
      end
      return n;
   endfunction

   function automatic logic ref_jump(input logic [5:0] jo, input logic [5:0] s);
      case (jo)
         6'h0D: return 1'b1;
         6'h0E: return s[0];
         6'h0F: return !s[0];
         6'h10: return s[1];
         6'h11: return s[1] | s[0];
         6'h12: return s[3];
         6'h13: return s[3] | s[0];
         default: return 1'b0;
      endcase
   endfunction

   task automatic check_status();
      string rq;
      if (prev_op == 6'h14) rq = "R2";
      else if (zero_writer(prev_op)) rq = "R3";
      else if (prev_op == 6'h0B || prev_op == 6'h0C) rq = "R8";
      else rq = "R9";
      chk(rq, "status", status_word, {26'h0, m_st});
   endtask

   task automatic step(input logic [5:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [15:0] im, input logic [4:0] sh, input logic hf, input logic [5:0] jo);
      logic [31:0] er;
      @(negedge clk);
      check_status();
      opcode = op; opnd_a = a; opnd_b = b; imm = im; shamt = sh; sext_half = hf; jump_op = jo;
      #1;
      er = ref_result(op, a, b, im, sh, hf);
      chk(req_of(op), "result", result, er);
      chk("R10", "jump_taken", {31'h0, jump_taken}, {31'h0, ref_jump(jo, m_st)});
      m_st = ref_flags(op, a, b, er, m_st);
      prev_op = op;
   endtask

   localparam logic [5:0] OPS [0:25] = '{
      6'h01, 6'h02, 6'h0B, 6'h0C, 6'h14, 6'h15, 6'h16, 6'h17, 6'h18, 6'h19,
      6'h1A, 6'h1B, 6'h1C, 6'h1D, 6'h1E, 6'h1F, 6'h20, 6'h21, 6'h25, 6'h26,
      6'h14, 6'h14, 6'h00, 6'h07, 6'h22, 6'h3F };

   initial begin
      #(4 * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1", "status in reset", status_word, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "status after reset", status_word, 32'h0);
      jump_op = 6'h0F; #1;
      chk("R10", "JNE after reset", {31'h0, jump_taken}, 32'h1);

      // compare corners: equal, signed less, overflowing greater
      step(6'h14, 32'd5, 32'd5, 16'h0, 5'd0, 1'b0, 6'h0E);
      step(6'h14, 32'hFFFF_FFFF, 32'd1, 16'h0, 5'd0, 1'b0, 6'h0E);
      step(6'h14, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 5'd0, 1'b0, 6'h12);
      step(6'h19, 32'h0, 32'h0, 16'h0, 5'd0, 1'b0, 6'h10);       // zero only; GT held
      step(6'h0B, 32'hDEAD_BEEF, 32'h0, 16'h1234, 5'd0, 1'b0, 6'h11); // LLI
      step(6'h0C, 32'hDEAD_BEEF, 32'h0, 16'hABCD, 5'd0, 1'b0, 6'h11); // LUI keeps low half
      step(6'h02, 32'h0000_0080, 32'h0, 16'h0, 5'd0, 1'b0, 6'h13);    // MOVS byte
      step(6'h02, 32'h0000_8000, 32'h0, 16'h0, 5'd0, 1'b1, 6'h13);    // MOVS half
      step(6'h02, 32'h1234_0000, 32'h0, 16'h0, 5'd0, 1'b1, 6'h0D);    // MOVS to zero
      step(6'h17, 32'h8000_0001, 32'd4, 16'h0, 5'd0, 1'b0, 6'h0F);    // shift by register
      step(6'h18, 32'h8000_0001, 32'd4, 16'h0, 5'd31, 1'b0, 6'h0F);   // literal wins
      step(6'h25, 32'd10, 32'h0, 16'hFFF6, 5'd0, 1'b0, 6'h0E);        // IADD -10
      step(6'h26, 32'd0, 32'h0, 16'h8000, 5'd0, 1'b0, 6'h0E);         // ISUB -32768
      step(6'h16, 32'd0, 32'h0, 16'h0, 5'd0, 1'b0, 6'h2A);            // DEC wraps
      step(6'h15, 32'hFFFF_FFFF, 32'h0, 16'h0, 5'd0, 1'b0, 6'h0D);    // INC to zero
      step(6'h07, 32'd3, 32'd3, 16'h0, 5'd0, 1'b0, 6'h0E);            // ignored code
      step(6'h14, 32'h8000_0000, 32'h8000_0000, 16'h0, 5'd0, 1'b0, 6'h13);

      for (int i = 0; i < 600; i++) begin
         logic [5:0]  op;
         logic [31:0] a, b;
         op = OPS[$urandom % 26];
         a  = ($urandom % 4 == 0) ? 32'($urandom % 4) : $urandom;
         b  = ($urandom % 4 == 0) ? a : $urandom;
         step(op, a, b, 16'($urandom), ($urandom % 2 == 0) ? 5'd0 : 5'($urandom),
              1'($urandom), 6'($urandom % 24));
      end
      @(negedge clk);
      check_status();

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule